// File: doc/BRIEF.md
# Flash Block Rewrite Sequencer

The sequencer replaces the contents of one flash erase block with words taken from a local buffer. A single `start` pulse latches the block offset, the buffer length, the bus width and the command-set identifier. The block then erases the block, waits for the erase to finish, and programs the buffer one bus-width word at a time, waiting for each word to complete. It speaks either of two command-set families. Family A issues its commands as single bus writes. Family B frames every command with two unlock writes that come before it.

Completion waiting is handed to an external completion poller through a request/answer pair. The sequencer asks for a poll with either the erase timeout or the write timeout selected, and the poller returns a result code. Any non-zero result aborts the rewrite. The device is always put back into read-array mode before `done` is raised, whether the rewrite succeeded or failed. Requests with an unknown command-set identifier or an inconsistent length/width pair are refused at once, and no bus write is made.

Top module: `flash_rewrite_seq`

## Requirements
- R1: Family A (identifier 0x0001 or 0x0003) erases with 0x20 and then 0xD0, both written at the block offset, one write per cycle.
- R2: Every family B (identifier 0x0002 or 0x0004) command takes three consecutive write cycles: 0xAA at unlock address 0xAAA, then 0x55 at acknowledge address 0x554, then the command byte. For an erase, both unlock addresses are offset by the block base.
- R3: Family B erases with an 0x80 setup command at base+0xAAA, followed by an 0x30 sector command written at the block offset.
- R4: In the cycle after the last erase write, `poll_go` is raised for one cycle with `poll_erase`=1 and `poll_addr` set to the block offset. No program write occurs until the poller answers with `poll_done`.
- R5: Each word is programmed by its command and then its data write in the very next cycle. Family A writes 0x40 at the word address. Family B writes an unlock-framed 0xA0 with no base added. The data write goes to block offset + byte index, with buffer word `byte index / width`, masked to the width.
- R6: The byte index starts at 0 and advances by the width (1, 2 or 4 bytes for `wsel` 0, 1, 2). Each data write is followed in the next cycle by a one-cycle `poll_go` with `poll_erase`=0.
- R7: A non-zero `poll_err` returned with `poll_done` stops further erase or program writes. The sequencer then goes to the read-array exit and reports that code on `err`.
- R8: Every accepted rewrite ends with 0xFF written at address 0. One cycle later, `done` pulses for one cycle with `err` (0 means success).
- R9: An identifier outside both families gives `done` one cycle after `start`, with `err`=1 (no device) and no bus write. This check takes priority over R10.
- R10: A `wsel` of 3, or a length that is not a multiple of the width, gives `done` one cycle after `start`, with `err`=2 (bad argument) and no bus write.
- R11: Every bus address (`fl_addr` and `poll_addr`) has its low address bits below the width cleared.
- R12: A zero length erases and polls the block, then goes straight to the read-array exit.
- R13: After reset there is no bus activity and `done` is low. A `start` pulse during a rewrite has no effect on the bus sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a rewrite (sampled while idle) |
| blk_ofs | input | ADDR_W | Byte offset of the block |
| buf_len | input | LEN_W | Buffer length in bytes |
| wsel | input | 2 | Bus width: 0=1, 1=2, 2=4 bytes |
| cmdset_id | input | 16 | Command-set identifier |
| buf_idx | output | LEN_W | Buffer word index to read |
| buf_data | input | 32 | Buffer word at `buf_idx`, same cycle |
| fl_we | output | 1 | Flash bus write strobe |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| poll_go | output | 1 | Completion poll request |
| poll_addr | output | ADDR_W | Address to poll |
| poll_erase | output | 1 | 1 selects the erase timeout, 0 the write timeout |
| poll_done | input | 1 | Poll finished |
| poll_err | input | 3 | Poll result, 0 means success |
| done | output | 1 | Rewrite finished (one-cycle pulse) |
| err | output | 3 | Result code, valid with `done` |

## Verification
The in-design assertions take for granted that the poller answers each `poll_go` exactly once and never raises `poll_done` unprompted. They also assume that `start` is not held across the cycle in which `done` is raised. The bench poller answers a fixed number of cycles after each request, and it can inject a chosen error code on a chosen poll. `start` is pulsed for a single cycle, except in the R13 case, where a second pulse is deliberately placed in the middle of a rewrite.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_NODEV   = 3'd1,
        ERR_BADARG  = 3'd2,
        ERR_TIMEOUT = 3'd3,
        ERR_LOCKED  = 3'd4,
        ERR_PROG    = 3'd5,
        ERR_ERASE   = 3'd6,
        ERR_OTHER   = 3'd7
    } fs_err_e;

    typedef enum logic [1:0] {FAM_NONE, FAM_A, FAM_B} fs_fam_e;
    typedef enum logic [1:0] {PH_ERASE, PH_PROG, PH_EXIT} fs_phase_e;
    typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_KICK, S_WAIT, S_FIN} fs_state_e;

    // where a write's address comes from
    typedef enum logic [2:0] {
        ASRC_ZERO, ASRC_BLK, ASRC_WORD, ASRC_UNLK, ASRC_ACK, ASRC_BLK_UNLK, ASRC_BLK_ACK
    } fs_asrc_e;

    typedef enum logic {DSRC_CMD, DSRC_BUF} fs_dsrc_e;

    typedef struct packed {
        fs_asrc_e    asrc;
        fs_dsrc_e    dsrc;
        logic [7:0]  code;
        logic        last;
    } fs_step_t;

    localparam logic [7:0] OP_A_ERASE   = 8'h20;
    localparam logic [7:0] OP_A_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_A_PROG    = 8'h40;
    localparam logic [7:0] OP_B_UNLK    = 8'hAA;
    localparam logic [7:0] OP_B_ACK     = 8'h55;
    localparam logic [7:0] OP_B_ESETUP  = 8'h80;
    localparam logic [7:0] OP_B_SECTOR  = 8'h30;
    localparam logic [7:0] OP_B_PROG    = 8'hA0;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;

    function automatic fs_step_t mk_step(fs_asrc_e a, fs_dsrc_e d, logic [7:0] c, logic l);
        fs_step_t s;
        s.asrc = a;
        s.dsrc = d;
        s.code = c;
        s.last = l;
        return s;
    endfunction

    function automatic logic [3:0] lane_bytes(logic [1:0] ws);
        return 4'(4'd1 << ws);
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(logic [1:0] ws);
        case (ws)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/flash_seq_argchk.sv
module flash_seq_argchk
    import flash_seq_pkg::*;
#(
    parameter int          LEN_W = 16,
    parameter logic [15:0] A_ID0 = 16'h0001,
    parameter logic [15:0] A_ID1 = 16'h0003,
    parameter logic [15:0] B_ID0 = 16'h0002,
    parameter logic [15:0] B_ID1 = 16'h0004
) (
    input  logic [15:0]      id,
    input  logic [1:0]       wsel,
    input  logic [LEN_W-1:0] len,
    output fs_fam_e          fam,
    output fs_err_e          verdict
);
    localparam int N_IDS = 4;
    localparam logic [15:0] ID_LIST [N_IDS] = '{A_ID0, A_ID1, B_ID0, B_ID1};

    logic [N_IDS-1:0] hit;

    for (genvar g = 0; g < N_IDS; g++) begin : g_match
        assign hit[g] = (id == ID_LIST[g]);
    end

    logic [LEN_W-1:0] low_bits;
    logic             misfit;

    assign low_bits = LEN_W'(lane_bytes(wsel) - 4'd1);
    assign misfit   = (wsel == 2'd3) || ((len & low_bits) != '0);

    always_comb begin
        if (hit[0] || hit[1])      fam = FAM_A;
        else if (hit[2] || hit[3]) fam = FAM_B;
        else                       fam = FAM_NONE;
    end

    always_comb begin
        if (fam == FAM_NONE) verdict = ERR_NODEV;
        else if (misfit)     verdict = ERR_BADARG;
        else                 verdict = ERR_NONE;
    end

endmodule

// File: rtl/flash_seq_cmdgen.sv
module flash_seq_cmdgen
    import flash_seq_pkg::*;
(
    input  fs_fam_e    fam,
    input  fs_phase_e  phase,
    input  logic [2:0] step,
    output fs_step_t   cur
);
    always_comb begin
        cur = mk_step(ASRC_ZERO, DSRC_CMD, OP_RD_ARRAY, 1'b1);
        unique case (phase)
            PH_ERASE: begin
                if (fam == FAM_A) begin
                    case (step)
                        3'd0:    cur = mk_step(ASRC_BLK, DSRC_CMD, OP_A_ERASE, 1'b0);
                        default: cur = mk_step(ASRC_BLK, DSRC_CMD, OP_A_CONFIRM, 1'b1);
                    endcase
                end else begin
                    case (step)
                        3'd0, 3'd3: cur = mk_step(ASRC_BLK_UNLK, DSRC_CMD, OP_B_UNLK, 1'b0);
                        3'd1, 3'd4: cur = mk_step(ASRC_BLK_ACK, DSRC_CMD, OP_B_ACK, 1'b0);
                        3'd2:       cur = mk_step(ASRC_BLK_UNLK, DSRC_CMD, OP_B_ESETUP, 1'b0);
                        default:    cur = mk_step(ASRC_BLK, DSRC_CMD, OP_B_SECTOR, 1'b1);
                    endcase
                end
            end
            PH_PROG: begin
                if (fam == FAM_A) begin
                    case (step)
                        3'd0:    cur = mk_step(ASRC_WORD, DSRC_CMD, OP_A_PROG, 1'b0);
                        default: cur = mk_step(ASRC_WORD, DSRC_BUF, 8'h00, 1'b1);
                    endcase
                end else begin
                    case (step)
                        3'd0:    cur = mk_step(ASRC_UNLK, DSRC_CMD, OP_B_UNLK, 1'b0);
                        3'd1:    cur = mk_step(ASRC_ACK, DSRC_CMD, OP_B_ACK, 1'b0);
                        3'd2:    cur = mk_step(ASRC_UNLK, DSRC_CMD, OP_B_PROG, 1'b0);
                        default: cur = mk_step(ASRC_WORD, DSRC_BUF, 8'h00, 1'b1);
                    endcase
                end
            end
            default: cur = mk_step(ASRC_ZERO, DSRC_CMD, OP_RD_ARRAY, 1'b1);
        endcase
    end

endmodule

// File: rtl/flash_rewrite_seq.sv
module flash_rewrite_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          LEN_W     = 16,
    parameter logic [15:0] A_ID0     = 16'h0001,
    parameter logic [15:0] A_ID1     = 16'h0003,
    parameter logic [15:0] B_ID0     = 16'h0002,
    parameter logic [15:0] B_ID1     = 16'h0004,
    parameter int          UNLK_ADDR = 'hAAA,
    parameter int          ACK_ADDR  = 'h554
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] blk_ofs,
    input  logic [LEN_W-1:0]  buf_len,
    input  logic [1:0]        wsel,
    input  logic [15:0]       cmdset_id,
    output logic [LEN_W-1:0]  buf_idx,
    input  logic [BUS_W-1:0]  buf_data,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BUS_W-1:0]  fl_wdata,
    output logic              poll_go,
    output logic [ADDR_W-1:0] poll_addr,
    output logic              poll_erase,
    input  logic              poll_done,
    input  logic [2:0]        poll_err,
    output logic              done,
    output logic [2:0]        err
);
    localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(UNLK_ADDR);
    localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_ADDR);

    // latched request
    fs_state_e        st_q;
    fs_phase_e        phase_q;
    logic [2:0]       step_q;
    fs_fam_e          fam_q;
    logic [1:0]       wsel_q;
    logic [ADDR_W-1:0] ofs_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] byte_i_q;
    fs_err_e          err_q;

    fs_fam_e  chk_fam;
    fs_err_e  chk_err;
    fs_step_t cur;

    flash_seq_argchk #(
        .LEN_W(LEN_W), .A_ID0(A_ID0), .A_ID1(A_ID1), .B_ID0(B_ID0), .B_ID1(B_ID1)
    ) u_chk (
        .id     (cmdset_id),
        .wsel   (wsel),
        .len    (buf_len),
        .fam    (chk_fam),
        .verdict(chk_err)
    );

    flash_seq_cmdgen u_gen (
        .fam  (fam_q),
        .phase(phase_q),
        .step (step_q),
        .cur  (cur)
    );

    // address and data formation
    logic [ADDR_W-1:0] raw_addr;
    logic [ADDR_W-1:0] align_keep;
    logic [LEN_W:0]    next_i;
    logic              last_word;

    assign align_keep = ~ADDR_W'(lane_bytes(wsel_q) - 4'd1);

    always_comb begin
        unique case (cur.asrc)
            ASRC_ZERO:     raw_addr = '0;
            ASRC_BLK:      raw_addr = ofs_q;
            ASRC_WORD:     raw_addr = ofs_q + ADDR_W'(byte_i_q);
            ASRC_UNLK:     raw_addr = UNLK_A;
            ASRC_ACK:      raw_addr = ACK_A;
            ASRC_BLK_UNLK: raw_addr = ofs_q + UNLK_A;
            ASRC_BLK_ACK:  raw_addr = ofs_q + ACK_A;
            default:       raw_addr = '0;
        endcase
    end

    assign fl_we    = (st_q == S_ISSUE);
    assign fl_addr  = fl_we ? (raw_addr & align_keep) : '0;
    assign fl_wdata = !fl_we ? '0 :
                      (cur.dsrc == DSRC_BUF) ? (buf_data & lane_mask(wsel_q))
                                             : BUS_W'(cur.code);
    assign buf_idx  = byte_i_q >> wsel_q;

    assign poll_go    = (st_q == S_KICK);
    assign poll_addr  = poll_go ? (ofs_q & align_keep) : '0;
    assign poll_erase = poll_go && (phase_q == PH_ERASE);

    assign done = (st_q == S_FIN);
    assign err  = err_q;

    assign next_i    = {1'b0, byte_i_q} + (LEN_W + 1)'(lane_bytes(wsel_q));
    assign last_word = (next_i == {1'b0, len_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            phase_q  <= PH_ERASE;
            step_q   <= '0;
            fam_q    <= FAM_NONE;
            wsel_q   <= '0;
            ofs_q    <= '0;
            len_q    <= '0;
            byte_i_q <= '0;
            err_q    <= ERR_NONE;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start) begin
                        err_q <= chk_err;
                        if (chk_err != ERR_NONE) begin
                            st_q <= S_FIN;
                        end else begin
                            fam_q    <= chk_fam;
                            wsel_q   <= wsel;
                            ofs_q    <= blk_ofs;
                            len_q    <= buf_len;
                            byte_i_q <= '0;
                            phase_q  <= PH_ERASE;
                            step_q   <= '0;
                            st_q     <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (cur.last) begin
                        step_q <= '0;
                        st_q   <= (phase_q == PH_EXIT) ? S_FIN : S_KICK;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                S_KICK: st_q <= S_WAIT;
                S_WAIT: begin
                    if (poll_done) begin
                        st_q   <= S_ISSUE;
                        step_q <= '0;
                        if (fs_err_e'(poll_err) != ERR_NONE) begin
                            err_q   <= fs_err_e'(poll_err);
                            phase_q <= PH_EXIT;
                        end else if (phase_q == PH_ERASE) begin
                            phase_q  <= (len_q == '0) ? PH_EXIT : PH_PROG;
                            byte_i_q <= '0;
                        end else if (last_word) begin
                            phase_q <= PH_EXIT;
                        end else begin
                            byte_i_q <= next_i[LEN_W-1:0];
                        end
                    end
                end
                S_FIN:   st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_POLL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        poll_go |-> $past(fl_we)); // R6

    AST_PROG_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (fl_we && phase_q == PH_PROG && cur.dsrc == DSRC_CMD) |=> fl_we); // R5

    AST_READ_ARRAY_LAST: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(start)) |->
        ($past(fl_we) && $past(fl_addr) == '0 && $past(fl_wdata) == BUS_W'(OP_RD_ARRAY))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && start && chk_err != ERR_NONE) |=>
        (done && !fl_we && err == $past(chk_err))); // R9

    AST_NO_WRITE_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WAIT && !poll_done) |=> !fl_we); // R4

endmodule

// File: tb/sim_flash_rewrite_seq.sv
module sim_flash_rewrite_seq;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] blk_ofs = '0;
    logic [15:0] buf_len = '0;
    logic [1:0]  wsel = '0;
    logic [15:0] cmdset_id = '0;
    logic [15:0] buf_idx;
    logic [31:0] buf_data;
    logic        fl_we;
    logic [23:0] fl_addr;
    logic [31:0] fl_wdata;
    logic        poll_go;
    logic [23:0] poll_addr;
    logic        poll_erase;
    logic        poll_done = 1'b0;
    logic [2:0]  poll_err = '0;
    logic        done;
    logic [2:0]  err;

    always #(CLK_NS / 2) clk = ~clk;

    flash_rewrite_seq u0 (
        .clk(clk), .rst(rst), .start(start), .blk_ofs(blk_ofs), .buf_len(buf_len),
        .wsel(wsel), .cmdset_id(cmdset_id), .buf_idx(buf_idx), .buf_data(buf_data),
        .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .poll_go(poll_go),
        .poll_addr(poll_addr), .poll_erase(poll_erase), .poll_done(poll_done),
        .poll_err(poll_err), .done(done), .err(err)
    );

    logic [31:0] bmem [0:31];
    assign buf_data = bmem[buf_idx[4:0]];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit we; int unsigned addr; int unsigned data;
        bit go; bit er; bit dn; int code;
    } exp_t;
    exp_t q[$];

    // poller configuration and behaviour
    int lat = 1;
    int fail_at = -1;
    int fail_code = 0;
    int pidx = 0;
    int pcnt = 0;
    int np = 0;

    always @(negedge clk) begin
        if (rst) begin
            pcnt = 0;
            poll_done <= 1'b0;
            poll_err <= '0;
        end else if (poll_go) begin
            pcnt = lat;
            poll_done <= 1'b0;
            poll_err <= '0;
        end else if (pcnt > 0) begin
            pcnt = pcnt - 1;
            if (pcnt == 0) begin
                poll_done <= 1'b1;
                poll_err <= (pidx == fail_at) ? 3'(fail_code) : 3'd0;
                pidx = pidx + 1;
            end
        end else begin
            poll_done <= 1'b0;
            poll_err <= '0;
        end
    end

    function automatic int unsigned al(int unsigned a, int wb);
        return (a & ~(wb - 1)) & 32'h00FF_FFFF;
    endfunction

    task automatic push(bit we, int unsigned a, int unsigned d, bit go, bit er, bit dn, int c);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.go = go; e.er = er; e.dn = dn; e.code = c;
        q.push_back(e);
    endtask

    task automatic wr(int unsigned a, int unsigned d, int wb);
        push(1, al(a, wb), d, 0, 0, 0, 0);
    endtask

    // one poll: request cycle, latency idle cycles; returns the injected code
    task automatic poll(int unsigned a, bit er, int wb, output int code);
        push(0, al(a, wb), 0, 1, er, 0, 0);
        for (int k = 0; k < lat; k++) push(0, 0, 0, 0, 0, 0, 0);
        code = (np == fail_at) ? fail_code : 0;
        np++;
    endtask

    task automatic model(int id, int ws, int len, int unsigned ofs);
        int wb;
        bit fa;
        bit fb;
        int e;
        int unsigned m;
        wb = 1 << ws;
        fa = (id == 1) || (id == 3);
        fb = (id == 2) || (id == 4);
        np = 0;
        if (!fa && !fb) begin
            push(0, 0, 0, 0, 0, 1, 1);            // R9
            return;
        end
        if (ws == 3 || (len % wb) != 0) begin
            push(0, 0, 0, 0, 0, 1, 2);            // R10
            return;
        end
        m = (wb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * wb)) - 1);
        if (fa) begin                              // R1
            wr(ofs, 'h20, wb);
            wr(ofs, 'hD0, wb);
        end else begin                             // R2 R3
            wr(ofs + 'hAAA, 'hAA, wb);
            wr(ofs + 'h554, 'h55, wb);
            wr(ofs + 'hAAA, 'h80, wb);
            wr(ofs + 'hAAA, 'hAA, wb);
            wr(ofs + 'h554, 'h55, wb);
            wr(ofs, 'h30, wb);
        end
        poll(ofs, 1, wb, e);                       // R4
        if (e == 0) begin
            for (int i = 0; i < len; i += wb) begin  // R5 R6
                if (fa) wr(ofs + i, 'h40, wb);
                else begin
                    wr('hAAA, 'hAA, wb);
                    wr('h554, 'h55, wb);
                    wr('hAAA, 'hA0, wb);
                end
                wr(ofs + i, bmem[i / wb] & m, wb);
                poll(ofs, 0, wb, e);
                if (e != 0) break;                 // R7
            end
        end
        wr(0, 'hFF, wb);                           // R8
        push(0, 0, 0, 0, 0, 1, e);
    endtask

    task automatic fail_line(string tag, string what, int unsigned act, int unsigned expv);
        bad++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    endtask

    task automatic run(string tag, int id, int ws, int len, int unsigned ofs,
                       int l, int fat, int fcode, bit poke);
        exp_t e;
        int n;
        bit ok;
        q.delete();
        lat = l; fail_at = fat; fail_code = fcode; pidx = 0;
        model(id, ws, len, ofs);
        @(negedge clk);
        cmdset_id = 16'(id); wsel = 2'(ws); buf_len = 16'(len); blk_ofs = 24'(ofs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (q.size() > 0) begin
            e = q.pop_front();
            ok = (fl_we == e.we) && (poll_go == e.go) && (done == e.dn);
            if (e.we) ok = ok && (32'(fl_addr) == e.addr) && (fl_wdata == e.data);
            if (e.go) ok = ok && (32'(poll_addr) == e.addr) && (poll_erase == e.er);
            if (e.dn) ok = ok && (32'(err) == 32'(e.code));
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s cycle %0d actual we=%0b a=%0h d=%0h go=%0b pa=%0h er=%0b dn=%0b err=%0d expected we=%0b a=%0h d=%0h go=%0b er=%0b dn=%0b err=%0d",
                         tag, n, fl_we, fl_addr, fl_wdata, poll_go, poll_addr, poll_erase, done, err,
                         e.we, e.addr, e.data, e.go, e.er, e.dn, e.code);
            end
            if (poke && n == 1) begin              // R13: start during a rewrite
                start = 1'b1; cmdset_id = 16'h0002; buf_len = 16'd0;
            end else if (poke && n == 2) begin
                start = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        total++;
        if (done !== 1'b0 || fl_we !== 1'b0) fail_line(tag, "idle after done", {done, fl_we}, 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++;
        fail_line("R13", "watchdog", 0, 1);
        summary();
    end

    initial begin
        for (int k = 0; k < 32; k++) bmem[k] = 32'hC3A5_0F10 ^ (32'(k) * 32'h0103_0507);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        total++;                                   // R13 reset state
        if (fl_we !== 1'b0 || poll_go !== 1'b0 || done !== 1'b0)
            fail_line("R13", "reset state", {fl_we, poll_go, done}, 0);

        run("R1 R5 R6", 1, 1, 6, 'h1000, 2, -1, 0, 0);
        run("R2 R3", 2, 0, 3, 'h2001, 1, -1, 0, 0);
        run("R11", 4, 2, 8, 'h3006, 3, -1, 0, 0);
        run("R7 erase-fail", 1, 1, 4, 'h400, 2, 0, 3, 0);
        run("R7 prog-fail", 2, 1, 6, 'h800, 1, 2, 5, 0);
        run("R9", 5, 1, 4, 'h0, 1, -1, 0, 0);
        run("R10 length", 1, 1, 3, 'h200, 1, -1, 0, 0);
        run("R10 width", 3, 3, 4, 'h200, 1, -1, 0, 0);
        run("R12", 3, 2, 0, 'h40, 2, -1, 0, 0);
        run("R13 busy-start", 1, 0, 2, 'h10, 4, -1, 0, 1);
        run("R4 R8", 4, 2, 4, 'h100, 5, -1, 0, 0);
        run("R1 R11 wide", 3, 2, 12, 'h5003, 1, -1, 0, 0);
        repeat (3) @(negedge clk);
        summary();
    end

endmodule